// File: doc/BRIEF.md
# Memory-Map Chip-Select Decoder

This block sits between a 16-bit processor bus and the memories and peripherals behind it. For every bus cycle it classifies the address into one of nine regions. From the region, the read/write line and a single stored map-type bit it forms a 3-bit select code. A downstream 3-to-8 decoder turns that code into chip selects. The block also drives a RAM enable and a ROM enable, and an outgoing address that redirects interrupt-vector reads.

The map-type bit chooses between two layouts. In the mixed layout, reads of the upper 32 KiB reach ROM and peripheral codes. In the all-RAM layout, every read below the I/O page selects RAM. Software switches layouts by writing to one of two fixed control addresses, and the data value of that write is ignored. Apart from that one register bit, every output is combinational in the current address, the read/write line and the stored map type.

Top module: `memsel_decoder`

## Requirements
- R1: With map type 0, a read of 0x0000-0x7FFF gives select code 0 and a write there gives code 7.
- R2: With map type 0, reads and writes give code 1 in 0x8000-0x9FFF, code 2 in 0xA000-0xBFFF and code 3 in 0xC000-0xFEFF.
- R3: In both map types and for both directions, the I/O page decodes as follows: code 4 for 0xFF00-0xFF1F, 5 for 0xFF20-0xFF3F, 6 for 0xFF40-0xFF5F and 7 for 0xFF60-0xFFDF.
- R4: With map type 1, every read of 0x0000-0xFEFF gives code 0. Writes to that range keep the codes of map type 0 (7, 1, 2, 3 by region).
- R5: 0xFFE0-0xFFFF gives code 2 in both map types and for both directions.
- R6: A qualified write cycle (cyc_valid_i=1 and rd_wr_n_i=0) to 0xFFDE clears the map type, and one to 0xFFDF sets it. The bit changes at the next rising clock edge. Reads of those addresses, unqualified cycles and writes to any other address leave the bit unchanged.
- R7: Reset (rst_n_i=0, asynchronous) forces map type 0.
- R8: ram_en_o is 1 exactly when the select code is 0, 2 or 7.
- R9: rom_en_o is 1 exactly when the select code is 2 and the cycle is a read (rd_wr_n_i=1). It is therefore never 1 during a write.
- R10: For a read of 0xFFF2-0xFFFF, addr_o equals the input address with bit 6 cleared, so the read is served from 0xFFB2-0xFFBF. In every other case addr_o equals addr_i.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock for the map-type register |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| addr_i | input | 16 | Bus address |
| rd_wr_n_i | input | 1 | 1 for a read cycle, 0 for a write cycle |
| cyc_valid_i | input | 1 | Marks a valid bus cycle; only gates the map-type update |
| sel_o | output | 3 | Select code |
| ram_en_o | output | 1 | RAM enable |
| rom_en_o | output | 1 | ROM enable, read cycles only |
| addr_o | output | 16 | Outgoing memory address after vector redirection |

## Verification
The only state is the map-type bit, and it is visible at the ports only through reads below 0xFF00. A wrong bit therefore shows up at once as code 0 where 1, 2 or 3 was expected, or the reverse, on the first read of 0x8000-0xFEFF after the faulty update. It also shows up in the ROM enable on any read of 0xA000-0xBFFF. Writes look the same under both map types, so a stuck bit goes unseen until a read is made. For that reason the bench probes with a read after every control write and after every ignored stimulus.

// File: rtl/memsel_pkg.sv
package memsel_pkg;

  localparam int ADDR_W = 16;
  localparam int SEL_W  = 3;
  localparam int VEC_FOLD_BIT = 6;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [SEL_W-1:0]  sel_t;

  typedef enum logic [3:0] {
    RG_LOW, RG_B8, RG_BA, RG_BC,
    RG_IO0, RG_IO1, RG_IO2, RG_IO3,
    RG_VEC
  } region_e;

  localparam addr_t BASE_B8   = 16'h8000;
  localparam addr_t BASE_BA   = 16'hA000;
  localparam addr_t BASE_BC   = 16'hC000;
  localparam addr_t BASE_IO0  = 16'hFF00;
  localparam addr_t BASE_IO1  = 16'hFF20;
  localparam addr_t BASE_IO2  = 16'hFF40;
  localparam addr_t BASE_IO3  = 16'hFF60;
  localparam addr_t BASE_VEC  = 16'hFFE0;
  localparam addr_t CTL_CLR   = 16'hFFDE;
  localparam addr_t CTL_SET   = 16'hFFDF;
  localparam addr_t VEC_FIRST = 16'hFFF2;

  localparam sel_t CODE_RAM_RD = 3'd0;
  localparam sel_t CODE_ROM    = 3'd2;
  localparam sel_t CODE_RAM_WR = 3'd7;

  // Region boundaries are compared from the top down.
  function automatic region_e classify(input addr_t a);
    region_e r;
    if      (a >= BASE_VEC) r = RG_VEC;
    else if (a >= BASE_IO3) r = RG_IO3;
    else if (a >= BASE_IO2) r = RG_IO2;
    else if (a >= BASE_IO1) r = RG_IO1;
    else if (a >= BASE_IO0) r = RG_IO0;
    else if (a >= BASE_BC)  r = RG_BC;
    else if (a >= BASE_BA)  r = RG_BA;
    else if (a >= BASE_B8)  r = RG_B8;
    else                    r = RG_LOW;
    return r;
  endfunction

  function automatic logic is_main_mem(input region_e r);
    return (r == RG_LOW) || (r == RG_B8) || (r == RG_BA) || (r == RG_BC);
  endfunction

  function automatic sel_t base_code(input region_e r, input logic rd);
    sel_t s;
    case (r)
      RG_LOW:  s = rd ? CODE_RAM_RD : CODE_RAM_WR;
      RG_B8:   s = 3'd1;
      RG_BA:   s = CODE_ROM;
      RG_BC:   s = 3'd3;
      RG_IO0:  s = 3'd4;
      RG_IO1:  s = 3'd5;
      RG_IO2:  s = 3'd6;
      RG_IO3:  s = 3'd7;
      RG_VEC:  s = CODE_ROM;
      default: s = CODE_RAM_WR;
    endcase
    return s;
  endfunction

  function automatic sel_t code_for(input region_e r, input logic rd,
                                    input logic all_ram);
    if (all_ram && rd && is_main_mem(r)) return CODE_RAM_RD;
    return base_code(r, rd);
  endfunction

  function automatic logic ram_hit(input sel_t s);
    return (s == CODE_RAM_RD) || (s == CODE_ROM) || (s == CODE_RAM_WR);
  endfunction

  function automatic logic vec_window(input addr_t a);
    return a >= VEC_FIRST;
  endfunction

  function automatic addr_t vec_fold(input addr_t a);
    addr_t r;
    r = a;
    r[VEC_FOLD_BIT] = 1'b0;
    return r;
  endfunction

endpackage

// File: rtl/memsel_region_dec.sv
module memsel_region_dec
  import memsel_pkg::*;
(
  input  addr_t   addr_i,
  output region_e region_o,
  output logic    main_mem_o
);
  always_comb begin
    region_o   = classify(addr_i);
    main_mem_o = is_main_mem(region_o);
  end
endmodule

// File: rtl/memsel_maptype_reg.sv
module memsel_maptype_reg
  import memsel_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_n_i,
  input  logic  wr_qual_i,
  input  addr_t addr_i,
  output logic  set_hit_o,
  output logic  clr_hit_o,
  output logic  all_ram_o
);
  always_comb begin
    set_hit_o = wr_qual_i && (addr_i == CTL_SET);
    clr_hit_o = wr_qual_i && (addr_i == CTL_CLR);
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)       all_ram_o <= 1'b0;
    else if (set_hit_o) all_ram_o <= 1'b1;
    else if (clr_hit_o) all_ram_o <= 1'b0;
  end
endmodule

// File: rtl/memsel_code_map.sv
module memsel_code_map
  import memsel_pkg::*;
(
  input  region_e region_i,
  input  logic    rd_i,
  input  logic    all_ram_i,
  output sel_t    sel_o,
  output logic    ram_en_o,
  output logic    rom_en_o
);
  sel_t code;

  always_comb begin
    code     = code_for(region_i, rd_i, all_ram_i);
    sel_o    = code;
    ram_en_o = ram_hit(code);
    rom_en_o = rd_i && (code == CODE_ROM);
  end
endmodule

// File: rtl/memsel_vector_remap.sv
module memsel_vector_remap
  import memsel_pkg::*;
#(
  parameter bit FOLD_EN = 1'b1
) (
  input  addr_t addr_i,
  input  logic  rd_i,
  output logic  vec_hit_o,
  output addr_t addr_o
);
  generate
    if (FOLD_EN) begin : g_fold
      always_comb begin
        vec_hit_o = rd_i && vec_window(addr_i);
        addr_o    = vec_hit_o ? vec_fold(addr_i) : addr_i;
      end
    end else begin : g_pass
      always_comb begin
        vec_hit_o = 1'b0;
        addr_o    = addr_i;
      end
    end
  endgenerate
endmodule

// File: rtl/memsel_decoder.sv
module memsel_decoder
  import memsel_pkg::*;
#(
  parameter bit VEC_FOLD_EN = 1'b1
) (
  input  logic        clk_i,
  input  logic        rst_n_i,
  input  logic [15:0] addr_i,
  input  logic        rd_wr_n_i,
  input  logic        cyc_valid_i,
  output logic [2:0]  sel_o,
  output logic        ram_en_o,
  output logic        rom_en_o,
  output logic [15:0] addr_o
);
  region_e region;
  logic    main_mem;
  logic    wr_qual;
  logic    set_hit;
  logic    clr_hit;
  logic    all_ram;
  logic    vec_hit;

  assign wr_qual = cyc_valid_i && !rd_wr_n_i;

  memsel_region_dec u_region (
    .addr_i     (addr_i),
    .region_o   (region),
    .main_mem_o (main_mem)
  );

  memsel_maptype_reg u_maptype (
    .clk_i     (clk_i),
    .rst_n_i   (rst_n_i),
    .wr_qual_i (wr_qual),
    .addr_i    (addr_i),
    .set_hit_o (set_hit),
    .clr_hit_o (clr_hit),
    .all_ram_o (all_ram)
  );

  memsel_code_map u_code (
    .region_i  (region),
    .rd_i      (rd_wr_n_i),
    .all_ram_i (all_ram),
    .sel_o     (sel_o),
    .ram_en_o  (ram_en_o),
    .rom_en_o  (rom_en_o)
  );

  memsel_vector_remap #(.FOLD_EN(VEC_FOLD_EN)) u_vec (
    .addr_i    (addr_i),
    .rd_i      (rd_wr_n_i),
    .vec_hit_o (vec_hit),
    .addr_o    (addr_o)
  );
endmodule

// File: rtl/memsel_decoder_chk.sv
module memsel_decoder_chk (
  input logic        clk_i,
  input logic        rst_n_i,
  input logic [15:0] addr_i,
  input logic        rd_wr_n_i,
  input logic [2:0]  sel_o,
  input logic        ram_en_o,
  input logic        rom_en_o,
  input logic [15:0] addr_o,
  input logic        main_mem,
  input logic        set_hit,
  input logic        clr_hit,
  input logic        all_ram,
  input logic        vec_hit
);
  // R9: no ROM enable on a write
  p_rom_no_write_r9: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !rd_wr_n_i |-> !rom_en_o);

  // R8: code 7 always brings RAM along
  p_ram_on_code7_r8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (sel_o == 3'd7) |-> ram_en_o);

  // R4: all-RAM reads of main memory select code 0
  p_allram_read_r4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (all_ram && rd_wr_n_i && main_mem) |-> (sel_o == 3'd0));

  // R1: a write to the low half is always code 7
  p_low_write_r1: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (!rd_wr_n_i && !addr_i[15]) |-> (sel_o == 3'd7));

  // R5: vector area is code 2
  p_vec_code_r5: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (addr_i[15:5] == 11'h7FF) |-> (sel_o == 3'd2));

  // R6: set and clear take effect at the next edge, otherwise hold
  p_set_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    set_hit |=> all_ram);
  p_clr_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    clr_hit |=> !all_ram);
  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !(set_hit || clr_hit) |=> $stable(all_ram));

  // R7: leaving reset in map type 0
  p_reset_r7: assert property (@(posedge clk_i)
    $rose(rst_n_i) |-> !all_ram);

  // R10: only bit 6 may change, and only on a vector fetch
  p_remap_bits_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (addr_o[15:7] == addr_i[15:7]) && (addr_o[5:0] == addr_i[5:0]));
  p_remap_only_vec_r10: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !vec_hit |-> (addr_o == addr_i));
endmodule

bind memsel_decoder memsel_decoder_chk u_chk (
  .clk_i     (clk_i),
  .rst_n_i   (rst_n_i),
  .addr_i    (addr_i),
  .rd_wr_n_i (rd_wr_n_i),
  .sel_o     (sel_o),
  .ram_en_o  (ram_en_o),
  .rom_en_o  (rom_en_o),
  .addr_o    (addr_o),
  .main_mem  (main_mem),
  .set_hit   (set_hit),
  .clr_hit   (clr_hit),
  .all_ram   (all_ram),
  .vec_hit   (vec_hit)
);

// File: tb/memsel_decoder_test.sv
module memsel_decoder_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] addr = 16'h0000;
  logic        rd = 1'b1;
  logic        vld = 1'b0;
  logic [2:0]  sel;
  logic        ram_en;
  logic        rom_en;
  logic [15:0] aout;

  int n_chk = 0;
  int n_bad = 0;

  always #5 clk = ~clk;

  memsel_decoder uut (
    .clk_i(clk), .rst_n_i(rst_n), .addr_i(addr), .rd_wr_n_i(rd),
    .cyc_valid_i(vld), .sel_o(sel), .ram_en_o(ram_en), .rom_en_o(rom_en),
    .addr_o(aout)
  );

  task automatic check(input logic ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Reference model written from numeric ranges
  function automatic int exp_sel(input int a, input bit r, input bit m);
    if (a < 32768)       return (r ? 0 : 7) ;
    else if (a < 65280) begin
      if (m && r)        return 0;
      else if (a < 40960) return 1;
      else if (a < 49152) return 2;
      else               return 3;
    end
    else if (a < 65312)  return 4;
    else if (a < 65344)  return 5;
    else if (a < 65376)  return 6;
    else if (a < 65504)  return 7;
    else                 return 2;
  endfunction

  function automatic string req_of(input int a, input bit m);
    if (a >= 65504)      return "R5";
    else if (a >= 65280) return "R3";
    else if (m)          return "R4";
    else if (a < 32768)  return "R1";
    else                 return "R2";
  endfunction

  task automatic ctl_write(input logic [15:0] a, input logic is_rd,
                           input logic v);
    @(negedge clk);
    addr = a; rd = is_rd; vld = v;
    @(posedge clk);
    @(negedge clk);
    vld = 1'b0; rd = 1'b1;
  endtask

  // Read probe at 0x8000: code 1 in map 0, code 0 in map 1
  task automatic probe_map(input bit m, input string req, input string what);
    @(negedge clk);
    addr = 16'h8000; rd = 1'b1; vld = 1'b0;
    #1;
    check(sel == (m ? 3'd0 : 3'd1), req, what, int'(sel), m ? 0 : 1);
  endtask

  task automatic sweep(input bit m);
    for (int r = 0; r < 2; r++) begin
      for (int a = 0; a < 65536; a++) begin
        int es;
        int ea;
        addr = a[15:0]; rd = r[0]; vld = 1'b0;
        #1;
        es = exp_sel(a, r[0], m);
        ea = (r == 1 && a >= 65522) ? a - 64 : a;
        check(int'(sel) == es, req_of(a, m), "sel", int'(sel), es);
        check(ram_en == (es == 0 || es == 2 || es == 7), "R8", "ram_en",
              int'(ram_en), int'(es == 0 || es == 2 || es == 7));
        check(rom_en == (es == 2 && r == 1), "R9", "rom_en",
              int'(rom_en), int'(es == 2 && r == 1));
        check(int'(aout) == ea, "R10", "addr_o", int'(aout), ea);
      end
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R7: map type 0 while held in reset
    addr = 16'h8000; rd = 1'b1;
    #2;
    check(sel == 3'd1, "R7", "sel in reset", int'(sel), 1);
    check(rom_en == 1'b0, "R7", "rom_en in reset", int'(rom_en), 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    probe_map(1'b0, "R7", "after reset");

    // Map type 0 exhaustive sweep; unqualified writes hit FFDE/FFDF too
    sweep(1'b0);
    probe_map(1'b0, "R6", "unqualified control writes ignored");

    // R6: reads and other addresses do not change the bit
    ctl_write(16'hFFDF, 1'b1, 1'b1);
    probe_map(1'b0, "R6", "read of set address ignored");
    ctl_write(16'hFFDD, 1'b0, 1'b1);
    probe_map(1'b0, "R6", "write to neighbour ignored");
    ctl_write(16'hFFDF, 1'b0, 1'b0);
    probe_map(1'b0, "R6", "write without valid ignored");

    // R6: set on next edge, check timing
    @(negedge clk);
    addr = 16'hFFDF; rd = 1'b0; vld = 1'b1;
    @(posedge clk);
    #1;
    vld = 1'b0; addr = 16'hA000; rd = 1'b1;
    #1;
    check(sel == 3'd0, "R6", "set after one edge", int'(sel), 0);
    check(rom_en == 1'b0, "R9", "no ROM in all-RAM read", int'(rom_en), 0);

    // Map type 1 sweep
    sweep(1'b1);
    probe_map(1'b1, "R6", "still set after sweep");
    ctl_write(16'hFFDE, 1'b1, 1'b1);
    probe_map(1'b1, "R6", "read of clear address ignored");
    ctl_write(16'hFFDF, 1'b0, 1'b1);
    probe_map(1'b1, "R6", "repeated set stays 1");

    // R6: clear
    ctl_write(16'hFFDE, 1'b0, 1'b1);
    probe_map(1'b0, "R6", "clear");

    // R7: reset from map type 1
    ctl_write(16'hFFDF, 1'b0, 1'b1);
    probe_map(1'b1, "R6", "set again");
    @(negedge clk) rst_n = 1'b0;
    #1;
    addr = 16'h8000; rd = 1'b1;
    #1;
    check(sel == 3'd1, "R7", "async reset clears", int'(sel), 1);
    @(negedge clk) rst_n = 1'b1;
    probe_map(1'b0, "R7", "after second reset");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule